// File: doc/BRIEF.md
# Nonvolatile Shadow Store/Recall Sequencer

This block governs a memory built from a fast SRAM with a nonvolatile shadow copy behind every cell. It watches two supply comparator flags: one says the supply is above the switch level, the other says it is above the lower reset level. It also watches the SRAM write strobe and a flag that marks an SRAM cycle still in flight. From these inputs it decides when to copy SRAM contents into the shadow (a store) and when to copy the shadow back into SRAM (a recall). It reports each operation through single-cycle start and done pulses, a busy flag, a write-inhibit gate and a standby-allowed flag.

A store on supply loss happens only when the SRAM is dirty, meaning it has taken at least one write since the last store or recall finished. A recall is requested only when the supply sinks below the reset level, which includes power-on. The recall begins only when the supply climbs back above the switch level. A shallow dip, in which the supply stays between the two levels, therefore causes no recall. All intervals are counted in clock cycles. Their defaults come from a clock-frequency parameter: a 1 µs grace window, a 10 ms store and a 550 µs recall. Every pin is a plain level or pulse, so the block has no valid/ready stream and no back-pressure.

Top module: `nvs_seq_ctrl`

## Requirements
- R1: During and right after reset, busy is 0 and no start or done pulse is given. A recall request is already pending, so with both supply flags high the first clock after reset enters the recall.
- R2: A pending recall starts in the first clock in which the sequencer is idle and sees sw_ok high. recall_start is 1 in the first cycle of the recall and recall_done is 1 in its last cycle. busy stays high for exactly RECALL_CYC cycles.
- R3: The recall request is set whenever rst_ok is low and is cleared when a recall starts. A dip of sw_ok while rst_ok stays high leaves no request behind.
- R4: The dirty state is set by a write that is accepted (wr_stb high while wr_inhibit is low). It is cleared when a store or a recall completes. A fall of sw_ok with the SRAM clean starts nothing.
- R5: When sw_ok falls with the SRAM dirty and rst_ok high, a grace window opens with busy high. The window ends after the first cycle in which cyc_pend is low, or after GRACE_CYC cycles, whichever comes first. The store starts in the next cycle.
- R6: A store lasts STORE_CYC cycles. store_start is 1 in its first cycle and store_done is 1 in its last.
- R7: wr_inhibit is 1 whenever sw_ok is low or a store or recall is running. A strobe given while wr_inhibit is 1 does not make the SRAM dirty.
- R8: A store_req pulse starts a grace window and then a store, even when the SRAM is clean, but only while the sequencer is idle and sw_ok is high. With sw_ok low the request is ignored.
- R9: If rst_ok falls during a grace window or a store, the sequencer returns to idle without giving store_done. The recall request is then set.
- R10: standby_ok equals deselect AND NOT busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_ok | input | 1 | Supply is above the switch level |
| rst_ok | input | 1 | Supply is above the reset level |
| wr_stb | input | 1 | SRAM write strobe |
| cyc_pend | input | 1 | An SRAM cycle is still in flight |
| store_req | input | 1 | Externally requested store |
| deselect | input | 1 | Chip is deselected (standby wanted) |
| store_start | output | 1 | First cycle of a store |
| store_done | output | 1 | Last cycle of a completed store |
| recall_start | output | 1 | First cycle of a recall |
| recall_done | output | 1 | Last cycle of a completed recall |
| busy | output | 1 | A grace window, store or recall is running |
| wr_inhibit | output | 1 | SRAM writes are blocked |
| standby_ok | output | 1 | Low-power standby may be entered |

## Verification
The hardest situation to reach is a deep supply loss in the middle of a store. It needs the SRAM dirty, a fall of sw_ok, and then a fall of rst_ok in a chosen cycle of the store interval. The expected outcome is an aborted store, followed later by a recall and not a second store. A directed sequence builds this up: a write, then a fall of sw_ok, then a wait until store_start is seen, then a fall of rst_ok a few cycles later. Random supply and strobe traffic around these directed cases checks the inhibit and standby rules in every cycle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_GRACE  = 2'd1,
    SQ_STORE  = 2'd2,
    SQ_RECALL = 2'd3
  } seq_state_t;
endpackage

// File: rtl/nvs_recall_latch.sv
module nvs_recall_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_ok,
  input  logic clr,
  output logic pend
);
  // Power-on counts as a reset-level loss: pending out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b1;
    else if (!rst_ok) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end

  a_r3_pend_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |=> pend);
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && rst_ok) |=> !pend);
endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_acc,
  input  logic clr,
  output logic dirty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dirty <= 1'b0;
    else if (clr)    dirty <= 1'b0;
    else if (wr_acc) dirty <= 1'b1;
  end

  a_r4_stays_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!dirty && !wr_acc) |=> !dirty);
  a_r4_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !clr) |=> dirty);
endmodule

// File: rtl/nvs_interval_cnt.sv
module nvs_interval_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl #(
  parameter int CLK_MHZ    = 50,
  parameter int GRACE_CYC  = CLK_MHZ,
  parameter int STORE_CYC  = CLK_MHZ * 10000,
  parameter int RECALL_CYC = CLK_MHZ * 550
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_ok,
  input  logic rst_ok,
  input  logic wr_stb,
  input  logic cyc_pend,
  input  logic store_req,
  input  logic deselect,
  output logic store_start,
  output logic store_done,
  output logic recall_start,
  output logic recall_done,
  output logic busy,
  output logic wr_inhibit,
  output logic standby_ok
);
  import nvs_pkg::*;

  localparam int MAX_A  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_C  = (MAX_A > GRACE_CYC) ? MAX_A : GRACE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] G_LAST = CNT_W'(GRACE_CYC - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] R_LAST = CNT_W'(RECALL_CYC - 1);

  seq_state_t       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             pend, dirty, wr_acc, restart;

  nvs_recall_latch u_latch (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok), .clr(recall_start), .pend(pend)
  );

  nvs_dirty_flag u_dirty (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc),
    .clr(store_done | recall_done), .dirty(dirty)
  );

  nvs_interval_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cnt(cnt)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE: begin
        if (!sw_ok) begin
          if (dirty && rst_ok) nxt = SQ_GRACE;
        end else if (pend) begin
          nxt = SQ_RECALL;
        end else if (store_req) begin
          nxt = SQ_GRACE;
        end
      end
      SQ_GRACE: begin
        if (!rst_ok)                       nxt = SQ_IDLE;
        else if (!cyc_pend || cnt == G_LAST) nxt = SQ_STORE;
      end
      SQ_STORE: begin
        if (!rst_ok || cnt == S_LAST) nxt = SQ_IDLE;
      end
      SQ_RECALL: begin
        if (!rst_ok || cnt == R_LAST) nxt = SQ_IDLE;
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  assign restart      = (nxt != state);
  assign store_start  = (state == SQ_STORE)  && (cnt == '0);
  assign recall_start = (state == SQ_RECALL) && (cnt == '0);
  assign store_done   = (state == SQ_STORE)  && rst_ok && (cnt == S_LAST);
  assign recall_done  = (state == SQ_RECALL) && rst_ok && (cnt == R_LAST);
  assign busy         = (state != SQ_IDLE);
  assign wr_inhibit   = !sw_ok || (state == SQ_STORE) || (state == SQ_RECALL);
  assign wr_acc       = wr_stb && !wr_inhibit;
  assign standby_ok   = deselect && !busy;

  a_r4_clean_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE && !sw_ok && !dirty) |=> state == SQ_IDLE);
  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done || recall_done) |=> !dirty);
  a_r6_store_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_STORE) |=> (state == SQ_STORE || state == SQ_IDLE));
  a_r2_recall_needs_sw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == SQ_RECALL) |-> $past(sw_ok));
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_STORE && !rst_ok) |-> !store_done);
endmodule

// File: tb/nvs_seq_ctrl_test.sv
module nvs_seq_ctrl_test;
  localparam int GC = 4, SC = 20, RC = 12;

  logic clk = 0, rst_n = 0;
  logic sw_ok = 1, rst_ok = 1, wr_stb = 0, cyc_pend = 0, store_req = 0, deselect = 0;
  logic store_start, store_done, recall_start, recall_done, busy, wr_inhibit, standby_ok;
  int checks = 0, fails = 0;
  int n_ss = 0, n_sd = 0, n_rs = 0, n_rd = 0;

  nvs_seq_ctrl #(.GRACE_CYC(GC), .STORE_CYC(SC), .RECALL_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .sw_ok(sw_ok), .rst_ok(rst_ok), .wr_stb(wr_stb),
    .cyc_pend(cyc_pend), .store_req(store_req), .deselect(deselect),
    .store_start(store_start), .store_done(store_done), .recall_start(recall_start),
    .recall_done(recall_done), .busy(busy), .wr_inhibit(wr_inhibit), .standby_ok(standby_ok)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    n_ss += int'(store_start); n_sd += int'(store_done);
    n_rs += int'(recall_start); n_rd += int'(recall_done);
  end

  function automatic bit exp_standby(bit desel, bit bsy);
    return desel && !bsy;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts busy cycles starting at the current negedge.
  task automatic busy_len(output int len);
    len = 0;
    while (busy && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic do_write();
    wr_stb = 1; step(1); wr_stb = 0;
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int len, ss0, sd0, rs0, rd0;
    step(2);
    chk(busy == 0 && !store_start && !recall_start, "R1 reset idle", int'(busy), 0);
    rst_n = 1;
    step(1);
    chk(recall_start == 1, "R1 power-on recall", int'(recall_start), 1);
    busy_len(len);
    chk(len == RC, "R2 recall length", len, RC);
    chk(n_rd == 1, "R2 recall_done pulse", n_rd, 1);

    // R4/R6: dirty store on a shallow dip, fast grace
    step(2); do_write();
    ss0 = n_ss; sd0 = n_sd; rs0 = n_rs;
    sw_ok = 0; step(1);
    chk(busy && !store_start, "R5 grace open", int'(busy), 1);
    busy_len(len);
    chk(len == 1 + SC, "R6 store length short grace", len, 1 + SC);
    chk(n_ss - ss0 == 1 && n_sd - sd0 == 1, "R6 one store", n_sd - sd0, 1);
    sw_ok = 1; step(RC + 5);
    chk(n_rs == rs0, "R3 no recall after shallow dip", n_rs - rs0, 0);

    // R5: full grace window with cycle still pending
    do_write(); cyc_pend = 1; sw_ok = 0; step(1);
    busy_len(len);
    chk(len == GC + SC, "R5 full grace", len, GC + SC);
    cyc_pend = 0;

    // R4/R7: clean dip, writes inhibited
    ss0 = n_ss; step(3);
    wr_stb = 1; step(1);
    chk(wr_inhibit == 1, "R7 inhibit when low", int'(wr_inhibit), 1);
    wr_stb = 0; step(5);
    sw_ok = 1; step(3); sw_ok = 0; step(SC + 5);
    chk(n_ss == ss0 && !busy, "R4 clean dip no store", n_ss - ss0, 0);

    // R8: external store ignored when low, honoured when high and clean
    store_req = 1; step(1); store_req = 0; step(3);
    chk(n_ss == ss0, "R8 ext store blocked low", n_ss - ss0, 0);
    sw_ok = 1; step(2);
    store_req = 1; step(1); store_req = 0;
    busy_len(len);
    chk(len == 1 + SC && n_ss == ss0 + 1, "R8 ext store clean", len, 1 + SC);

    // R10: standby follows deselect and busy
    deselect = 1; step(1);
    chk(standby_ok == 1, "R10 standby idle", int'(standby_ok), 1);
    store_req = 1; step(1); store_req = 0;
    chk(standby_ok == 0, "R10 standby deferred", int'(standby_ok), 0);
    busy_len(len); deselect = 0;

    // R9: deep loss during store aborts, then recall; recall clears dirty
    do_write(); sd0 = n_sd; rs0 = n_rs; rd0 = n_rd;
    sw_ok = 0;
    while (!store_start) step(1);
    step(5); rst_ok = 0; step(1);
    chk(!busy, "R9 abort to idle", int'(busy), 0);
    step(SC + 5);
    chk(n_sd == sd0, "R9 no store_done on abort", n_sd - sd0, 0);
    rst_ok = 1; sw_ok = 1; step(1);
    chk(recall_start == 1, "R3 recall after deep loss", int'(recall_start), 1);
    busy_len(len);
    chk(n_rd == rd0 + 1, "R2 recall done after abort", n_rd - rd0, 1);
    ss0 = n_ss; sw_ok = 0; step(SC + 5);
    chk(n_ss == ss0, "R4 recall cleared dirty", n_ss - ss0, 0);
    sw_ok = 1; step(3);

    // Random traffic with per-cycle rule checks (R7, R10)
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) sw_ok = $urandom_range(0, 1);
      if ($urandom_range(0, 49) == 0) rst_ok = $urandom_range(0, 3) != 0;
      if (rst_ok == 0) sw_ok = 0;
      wr_stb    = $urandom_range(0, 3) == 0;
      cyc_pend  = $urandom_range(0, 1);
      store_req = $urandom_range(0, 63) == 0;
      deselect  = $urandom_range(0, 1);
      step(1);
      if (!sw_ok) chk(wr_inhibit == 1, "R7 random inhibit", int'(wr_inhibit), 1);
      chk(standby_ok == exp_standby(deselect, busy), "R10 random standby",
          int'(standby_ok), int'(exp_standby(deselect, busy)));
      chk(!(store_start && recall_start), "R2 exclusive starts", 1, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule